// File: doc/BRIEF.md
# Nibble-Wide Constant Table Reader

This unit lets a 4-bit datapath fetch constant bytes stored in program memory. A 12-bit table pointer is assembled from the accumulator one nibble at a time, using three separate write strobes, one for each 4-bit field. The pointer always addresses the upper half of a 13-bit program memory, so the memory address is the pointer with bit 12 forced high.

Each stored byte is consumed as two nibbles. A low-nibble read returns bits 3:0 of the addressed byte and leaves the pointer where it is. A high-nibble read returns bits 7:4 and then steps the pointer to the next byte. Sequential tables can therefore be walked with alternating low and high reads and no extra pointer arithmetic. The memory is synchronous with one cycle of latency. The nibble and its valid flag appear on the cycle after the command.

Top module: `nib_table_reader`

## Requirements
- R1: While and after a synchronous active-high reset, the pointer is 000h (rom_addr = 1000h), result_valid is 0, rom_rd_en is 0 and result is 0.
- R2: wr_ptr_lo, wr_ptr_mid and wr_ptr_hi load acc_in into pointer bits 3:0, 7:4 and 11:8 respectively on the next clock edge. Every other pointer field keeps its value.
- R3: rom_addr always equals 1000h plus the 12-bit pointer, so bit 12 of rom_addr is always 1.
- R4: A low read (rd_lo_cmd) raises rom_rd_en in the command cycle. In the following cycle, result_valid is 1 and result holds bits 3:0 of the addressed byte. The pointer is unchanged.
- R5: A high read (rd_hi_cmd) raises rom_rd_en in the command cycle. In the following cycle, result_valid is 1 and result holds bits 7:4 of the byte at the pointer value of the command cycle. The pointer is then one greater.
- R6: Incrementing the pointer from FFFh gives 000h.
- R7: When rd_lo_cmd and rd_hi_cmd are both asserted, the unit performs a high read.
- R8: When any pointer write coincides with a high read, the byte is still read at the old pointer. The write is applied and the increment is dropped.
- R9: result_valid is 1 only in the cycle after a read command. While it is 0, result is 0.
- R10: With the pointer at 777h and byte 56h at 1777h, a low read returns 6h and the following high read returns 5h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_in | input | 4 | Accumulator value for pointer writes |
| wr_ptr_lo | input | 1 | Load pointer bits 3:0 |
| wr_ptr_mid | input | 1 | Load pointer bits 7:4 |
| wr_ptr_hi | input | 1 | Load pointer bits 11:8 |
| rd_lo_cmd | input | 1 | Low-nibble read command |
| rd_hi_cmd | input | 1 | High-nibble read with post-increment |
| rom_addr | output | 13 | Program memory address (upper bank) |
| rom_rd_en | output | 1 | Program memory read enable |
| rom_data | input | 8 | Program memory byte, valid one cycle after rom_rd_en |
| result | output | 4 | Selected nibble for the accumulator |
| result_valid | output | 1 | result carries a fetched nibble |

## Verification
The bench walks the pointer across the FFFh boundary. A design without the wrap would either leave the upper bank or stall at FFFh. It issues a high read in the same cycle as a pointer write. A design that increments after the write, or that reads at the new pointer, returns the wrong nibble or lands one byte off. It asserts both read commands together, which catches a decoder that favours the low read. It rewrites single fields and checks that the other two fields are untouched, which exposes any write that clobbers neighbouring bits.

// File: rtl/nibtab_pkg.sv
package nibtab_pkg;
    localparam int NIB_W  = 4;
    localparam int PTR_W  = 12;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_LO   = 2'd1,
        RD_HI   = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic valid;
        logic hi;
    } pend_t;

    // High read dominates when both commands arrive together
    function automatic rd_kind_e decode_rd(input logic lo, input logic hi);
        if (hi)      return RD_HI;
        else if (lo) return RD_LO;
        else         return RD_NONE;
    endfunction

    function automatic logic [NIB_W-1:0] pick_nib(input logic [BYTE_W-1:0] b,
                                                  input logic hi);
        return hi ? b[BYTE_W-1:NIB_W] : b[NIB_W-1:0];
    endfunction
endpackage

// File: rtl/nt_pointer.sv
module nt_pointer
    import nibtab_pkg::*;
#(
    parameter int P_W = PTR_W,
    parameter int N_W = NIB_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_W-1:0]           acc,
    input  logic [P_W/N_W-1:0]       fld_wr,
    input  logic                     inc,
    output logic [P_W-1:0]           ptr
);
    localparam int NF = P_W / N_W;

    logic           any_wr;
    logic [P_W-1:0] ptr_inc;

    assign any_wr  = |fld_wr;
    assign ptr_inc = ptr + {{(P_W-1){1'b0}}, 1'b1};

    for (genvar g = 0; g < NF; g++) begin : g_fld
        logic [N_W-1:0] fld_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q <= '0;
            end else if (any_wr) begin
                if (fld_wr[g]) fld_q <= acc;
            end else if (inc) begin
                fld_q <= ptr_inc[g*N_W +: N_W];
            end
        end
        assign ptr[g*N_W +: N_W] = fld_q;
    end
endmodule

// File: rtl/nt_fetch.sv
module nt_fetch
    import nibtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_kind_e          kind,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              rd_en,
    output logic [NIB_W-1:0]  nib,
    output logic              nib_valid
);
    pend_t pend_q;

    assign rd_en = (kind != RD_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q.valid <= rd_en;
            pend_q.hi    <= (kind == RD_HI);
        end
    end

    assign nib_valid = pend_q.valid;
    assign nib       = pend_q.valid ? pick_nib(rom_data, pend_q.hi) : '0;
endmodule

// File: rtl/nib_table_reader.sv
module nib_table_reader
    import nibtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  acc_in,
    input  logic              wr_ptr_lo,
    input  logic              wr_ptr_mid,
    input  logic              wr_ptr_hi,
    input  logic              rd_lo_cmd,
    input  logic              rd_hi_cmd,
    output logic [PTR_W:0]    rom_addr,
    output logic              rom_rd_en,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [NIB_W-1:0]  result,
    output logic              result_valid
);
    localparam int NF = PTR_W / NIB_W;

    rd_kind_e         kind;
    logic [PTR_W-1:0] ptr;
    logic [NF-1:0]    fld_wr;

    assign kind   = decode_rd(rd_lo_cmd, rd_hi_cmd);
    assign fld_wr = {wr_ptr_hi, wr_ptr_mid, wr_ptr_lo};

    nt_pointer #(.P_W(PTR_W), .N_W(NIB_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc_in),
        .fld_wr (fld_wr),
        .inc    (kind == RD_HI),
        .ptr    (ptr)
    );

    nt_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .rom_data  (rom_data),
        .rd_en     (rom_rd_en),
        .nib       (result),
        .nib_valid (result_valid)
    );

    // Upper bank: base is 2**PTR_W
    assign rom_addr = {1'b1, ptr};
endmodule

// File: rtl/nt_checker.sv
module nt_checker
    import nibtab_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NIB_W-1:0]  acc_in,
    input logic              wr_ptr_lo,
    input logic              wr_ptr_mid,
    input logic              wr_ptr_hi,
    input logic              rd_lo_cmd,
    input logic              rd_hi_cmd,
    input logic [PTR_W:0]    rom_addr,
    input logic              rom_rd_en,
    input logic [BYTE_W-1:0] rom_data,
    input logic [NIB_W-1:0]  result,
    input logic              result_valid
);
    logic any_wr;
    logic any_rd;
    assign any_wr = wr_ptr_lo | wr_ptr_mid | wr_ptr_hi;
    assign any_rd = rd_lo_cmd | rd_hi_cmd;

    assert_valid_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        any_rd |=> result_valid);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !any_rd |=> !result_valid);

    assert_idle_result_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> (result == '0));

    assert_hi_advances_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_hi_cmd && !any_wr) |=> (rom_addr[PTR_W-1:0] == $past(rom_addr[PTR_W-1:0]) + 1'b1));

    assert_lo_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_lo_cmd && !rd_hi_cmd && !any_wr) |=> $stable(rom_addr));

    assert_lo_field_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr_lo && !wr_ptr_mid && !wr_ptr_hi && !rd_hi_cmd) |=>
        (rom_addr[NIB_W-1:0] == $past(acc_in) &&
         rom_addr[PTR_W-1:NIB_W] == $past(rom_addr[PTR_W-1:NIB_W])));

    assert_write_beats_inc_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_hi_cmd && wr_ptr_hi && !wr_ptr_lo && !wr_ptr_mid) |=>
        (rom_addr[NIB_W-1:0] == $past(rom_addr[NIB_W-1:0])));
endmodule

bind nib_table_reader nt_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_in       (acc_in),
    .wr_ptr_lo    (wr_ptr_lo),
    .wr_ptr_mid   (wr_ptr_mid),
    .wr_ptr_hi    (wr_ptr_hi),
    .rd_lo_cmd    (rd_lo_cmd),
    .rd_hi_cmd    (rd_hi_cmd),
    .rom_addr     (rom_addr),
    .rom_rd_en    (rom_rd_en),
    .rom_data     (rom_data),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/tb_nib_table_reader.sv
module tb_nib_table_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  acc_in = '0;
    logic        wr_ptr_lo = 0, wr_ptr_mid = 0, wr_ptr_hi = 0;
    logic        rd_lo_cmd = 0, rd_hi_cmd = 0;
    logic [12:0] rom_addr;
    logic        rom_rd_en;
    logic [7:0]  rom_data = '0;
    logic [3:0]  result;
    logic        result_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [11:0] exp_ptr = '0;

    always #10 clk = ~clk;

    nib_table_reader dut (
        .clk(clk), .rst(rst), .acc_in(acc_in),
        .wr_ptr_lo(wr_ptr_lo), .wr_ptr_mid(wr_ptr_mid), .wr_ptr_hi(wr_ptr_hi),
        .rd_lo_cmd(rd_lo_cmd), .rd_hi_cmd(rd_hi_cmd),
        .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .rom_data(rom_data),
        .result(result), .result_valid(result_valid)
    );

    function automatic logic [7:0] rom_byte(input logic [12:0] a);
        if (a == 13'h1777) return 8'h56;
        if (!a[12])        return 8'hEE;
        return a[7:0] ^ {a[11:8], 4'hA} ^ 8'h3C;
    endfunction

    always_ff @(posedge clk)
        if (rom_rd_en) rom_data <= rom_byte(rom_addr);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive one command cycle starting at a negedge; return at the next negedge
    task automatic cmd(input logic lo, input logic hi, input logic wl, input logic wm,
                       input logic wh, input logic [3:0] acc, output logic rden);
        rd_lo_cmd = lo; rd_hi_cmd = hi;
        wr_ptr_lo = wl; wr_ptr_mid = wm; wr_ptr_hi = wh; acc_in = acc;
        #1 rden = rom_rd_en;
        @(negedge clk);
        rd_lo_cmd = 0; rd_hi_cmd = 0; wr_ptr_lo = 0; wr_ptr_mid = 0; wr_ptr_hi = 0;
    endtask

    task automatic set_ptr(input logic [11:0] v);
        logic rd;
        cmd(0, 0, 1, 0, 0, v[3:0], rd);
        cmd(0, 0, 0, 1, 0, v[7:4], rd);
        cmd(0, 0, 0, 0, 1, v[11:8], rd);
        exp_ptr = v;
    endtask

    task automatic rd_lo(input string req);
        logic rd;
        logic [12:0] a;
        a = {1'b1, exp_ptr};
        cmd(1, 0, 0, 0, 0, 4'h0, rd);
        chk({req, " rd_en"}, 16'(rd), 16'h1);
        chk({req, " valid"}, 16'(result_valid), 16'h1);
        chk({req, " nib"}, 16'(result), 16'(rom_byte(a) & 8'h0F));
        chk({req, " ptr"}, 16'(rom_addr), 16'(a));
    endtask

    task automatic rd_hi(input string req);
        logic rd;
        logic [12:0] a;
        a = {1'b1, exp_ptr};
        cmd(0, 1, 0, 0, 0, 4'h0, rd);
        exp_ptr = exp_ptr + 12'd1;
        chk({req, " rd_en"}, 16'(rd), 16'h1);
        chk({req, " valid"}, 16'(result_valid), 16'h1);
        chk({req, " nib"}, 16'(result), 16'(rom_byte(a) >> 4));
        chk({req, " ptr"}, 16'(rom_addr), 16'({1'b1, exp_ptr}));
    endtask

    task automatic t_reset();
        chk("R1 addr", 16'(rom_addr), 16'h1000);
        chk("R1 valid", 16'(result_valid), 16'h0);
        chk("R1 rd_en", 16'(rom_rd_en), 16'h0);
        chk("R1 result", 16'(result), 16'h0);
    endtask

    task automatic t_fields();
        logic rd;
        cmd(0, 0, 1, 0, 0, 4'h3, rd); chk("R2 lo", 16'(rom_addr), 16'h1003);
        chk("R9 no valid on write", 16'(result_valid), 16'h0);
        cmd(0, 0, 0, 1, 0, 4'hA, rd); chk("R2 mid", 16'(rom_addr), 16'h10A3);
        cmd(0, 0, 0, 0, 1, 4'h5, rd); chk("R2 hi", 16'(rom_addr), 16'h15A3);
        cmd(0, 0, 1, 0, 0, 4'hF, rd); chk("R2 lo rewrite", 16'(rom_addr), 16'h15AF);
        chk("R2 rd_en low on write", 16'(rd), 16'h0);
        exp_ptr = 12'h5AF;
    endtask

    task automatic t_example();
        set_ptr(12'h777);
        rd_lo("R10 low 6h");
        rd_hi("R10 high 5h");
        chk("R10 value", 16'(result), 16'h5);
    endtask

    task automatic t_lo_repeat();
        set_ptr(12'h42B);
        rd_lo("R4 first");
        rd_lo("R4 repeat");
    endtask

    task automatic t_wrap();
        set_ptr(12'hFFF);
        rd_hi("R6 wrap");
        chk("R6 addr 1000h", 16'(rom_addr), 16'h1000);
        rd_lo("R6 after wrap");
    endtask

    task automatic t_both();
        logic rd;
        logic [12:0] a;
        set_ptr(12'h123);
        a = {1'b1, exp_ptr};
        cmd(1, 1, 0, 0, 0, 4'h0, rd);
        exp_ptr = exp_ptr + 12'd1;
        chk("R7 valid", 16'(result_valid), 16'h1);
        chk("R7 nib", 16'(result), 16'(rom_byte(a) >> 4));
        chk("R7 ptr", 16'(rom_addr), 16'({1'b1, exp_ptr}));
    endtask

    task automatic t_wr_hi();
        logic rd;
        logic [12:0] a;
        set_ptr(12'h124);
        a = {1'b1, exp_ptr};
        cmd(0, 1, 0, 1, 0, 4'h9, rd);
        chk("R8 nib old addr", 16'(result), 16'(rom_byte(a) >> 4));
        chk("R8 ptr no inc", 16'(rom_addr), 16'h1194);
        exp_ptr = 12'h194;
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R9 idle valid", 16'(result_valid), 16'h0);
        chk("R9 idle result", 16'(result), 16'h0);
    endtask

    task automatic t_stream();
        set_ptr(12'h2FE);
        for (int i = 0; i < 3; i++) begin
            rd_lo("R5 stream lo");
            rd_hi("R5 stream hi");
            chk("R3 bank bit", 16'(rom_addr[12]), 16'h1);
        end
        chk("R3 addr after stream", 16'(rom_addr), 16'h1301);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_example();
        t_lo_repeat();
        t_wrap();
        t_both();
        t_wr_hi();
        t_idle();
        t_stream();
        finish_run();
    end
endmodule